// File: doc/BRIEF.md
# Triggered Integration Window Controller

This block sums a stream of decimated, signed filter results over a window that an external trigger line opens. Once a trigger event is seen, integration is enabled, a programmed number of incoming results is thrown away to let the signal settle, and then results are added in groups. Each group holds a programmed number of results. When a group is complete, the sum leaves the block with a one-cycle valid pulse and a new group starts from zero.

The window closes in one of two ways. Under internal control it closes by itself after a programmed number of groups. Under external control it closes when the trigger line makes the transition opposite to the one that opened it. A 2-bit trigger mode selects one of four behaviours: the integrator is bypassed and results pass straight through, a falling edge opens the window, a rising edge opens it, or integration runs permanently without any trigger. Status outputs report how many results are in the current group, how many groups have been completed in the window, and whether integration is enabled.

The controller is built from four parts. `intwin_trig` registers the previous trigger level and turns edges into start and stop events. `intwin_fsm` holds the window state. `intwin_datapath` holds the counters and the accumulator. The top module joins them.

- The states of `intwin_fsm` are `ST_IDLE` (waiting for a start event), `ST_DISCARD` (dropping settling results) and `ST_INTEG` (summing results).
- The transitions out of `ST_IDLE`:
  - `ST_IDLE -> ST_DISCARD` on a start event when the discard count is non-zero.
  - `ST_IDLE -> ST_INTEG` on a start event when the discard count is zero.
- The transitions out of `ST_DISCARD`:
  - `ST_DISCARD -> ST_INTEG` on the last discarded result.
  - `ST_DISCARD -> ST_IDLE` on a stop event or on bypass.
- The transitions out of `ST_INTEG`:
  - `ST_INTEG -> ST_INTEG` when a group completes and the window continues.
  - `ST_INTEG -> ST_IDLE` on a stop event, on bypass, or when the last group of an internally controlled window completes.

Top module: `intwin_ctrl`

## Requirements
- R1: When `trig_mode` is 0 (bypass), `integ_en` is 0 from the cycle after the mode is applied. Each result with `res_valid` high appears sign-extended on `sum_out`, with `sum_valid` high, in the following cycle. Trigger edges have no effect in this mode.
- R2: When `trig_mode` is 3, `integ_en` is 1 permanently. Integration begins without any trigger edge and never ends by itself, whatever `win_ext` and `repeat_val` hold.
- R3: When `trig_mode` is 1, a falling edge of `trig_in` opens the window. When `trig_mode` is 2, a rising edge opens it. `integ_en` reads 1 in the cycle after the clock edge at which the new trigger level is first sampled.
- R4: After the window opens, the first `discard_cnt` valid results are dropped without being counted or summed. A value of 0 drops none.
- R5: Each group sums `integ_cnt`+1 valid results. The sum appears on `sum_out` with `sum_valid` high for exactly one cycle, in the cycle after the last result of the group. At the same edge the accumulator and `vals_counted` return to 0.
- R6: `vals_counted` shows how many results have been summed so far in the current group.
- R7: With `win_ext` at 0, the window closes after `repeat_val`+1 groups. `integ_en` drops in the same cycle that the last sum is output. `cycle_count` counts completed groups modulo 8, is cleared when a window opens, and holds its value after the window closes.
- R8: With `win_ext` at 1, the window closes on the trigger transition opposite to the opening one, and `repeat_val` has no effect. A partly summed group is dropped without a `sum_valid` pulse, and `vals_counted` returns to 0.
- R9: Opening edges that arrive while the window is open are ignored. They do not clear `cycle_count` and do not restart the discard phase.
- R10: The accumulator holds 32 full-scale 15-bit results of either sign without overflow. For example, 32 results of -16384 sum to -524288.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_mode | input | 2 | 0 bypass, 1 falling edge, 2 rising edge, 3 always on |
| win_ext | input | 1 | 0 internal group count, 1 closed by opposite trigger transition |
| discard_cnt | input | 5 | Results dropped after the window opens |
| integ_cnt | input | 5 | Results per group minus one |
| repeat_val | input | 3 | Groups per internal window minus one |
| trig_in | input | 1 | External trigger line |
| res_data | input | 15 | Signed filter result |
| res_valid | input | 1 | Result strobe |
| sum_out | output | 20 | Signed group sum, or passed-through result in bypass |
| sum_valid | output | 1 | One-cycle pulse marking `sum_out` |
| vals_counted | output | 5 | Results summed in the current group |
| cycle_count | output | 3 | Groups completed in the current window |
| integ_en | output | 1 | Integration enabled |

## Verification
`integ_en` changes one clock edge after the trigger level that causes the change is first sampled. `sum_valid`, `sum_out`, `vals_counted` and `cycle_count` all update at the same edge that consumes a result, so each of them is due one edge after its stimulus. The bench drives every input on the falling clock edge and reads the outputs on the next falling edge, exactly one rising edge later. For this reason every check reads the value belonging to the stimulus just applied, and never the value from one cycle earlier or later.

// File: rtl/intwin_pkg.sv
package intwin_pkg;

    typedef enum logic [1:0] {
        TRM_BYPASS = 2'd0,
        TRM_FALL   = 2'd1,
        TRM_RISE   = 2'd2,
        TRM_ALWAYS = 2'd3
    } trig_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_DISCARD = 2'd1,
        ST_INTEG   = 2'd2
    } win_state_e;

endpackage

// File: rtl/intwin_trig.sv
module intwin_trig
    import intwin_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  trig_mode_e mode,
    input  logic       win_ext,
    input  logic       trig_in,
    output logic       start_evt,
    output logic       stop_evt
);

    logic trig_prev;
    logic rise;
    logic fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig_prev <= 1'b0;
        end else begin
            trig_prev <= trig_in;
        end
    end

    assign rise = trig_in & ~trig_prev;
    assign fall = ~trig_in & trig_prev;

    always_comb begin
        start_evt = 1'b0;
        stop_evt  = 1'b0;
        unique case (mode)
            TRM_BYPASS: begin
                start_evt = 1'b0;
                stop_evt  = 1'b0;
            end
            TRM_FALL: begin
                start_evt = fall;
                stop_evt  = win_ext & rise;
            end
            TRM_RISE: begin
                start_evt = rise;
                stop_evt  = win_ext & fall;
            end
            TRM_ALWAYS: begin
                start_evt = 1'b1;
                stop_evt  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/intwin_fsm.sv
module intwin_fsm
    import intwin_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bypass,
    input  logic       always_on,
    input  logic       win_ext,
    input  logic       start_evt,
    input  logic       stop_evt,
    input  logic       res_valid,
    input  logic       disc_zero,
    input  logic       disc_last,
    input  logic       vals_last,
    input  logic       cycle_last,
    output win_state_e state_q,
    output logic       win_start,
    output logic       win_abort,
    output logic       disc_take,
    output logic       acc_take,
    output logic       cyc_done
);

    win_state_e state_d;
    logic       last_group;

    assign last_group = ~win_ext & ~always_on & cycle_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!bypass && start_evt) begin
                    state_d = disc_zero ? ST_INTEG : ST_DISCARD;
                end
            end
            ST_DISCARD: begin
                if (bypass || stop_evt) begin
                    state_d = ST_IDLE;
                end else if (res_valid && disc_last) begin
                    state_d = ST_INTEG;
                end
            end
            ST_INTEG: begin
                if (bypass || stop_evt) begin
                    state_d = ST_IDLE;
                end else if (res_valid && vals_last && last_group) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        win_start = 1'b0;
        win_abort = 1'b0;
        disc_take = 1'b0;
        acc_take  = 1'b0;
        cyc_done  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                win_start = ~bypass & start_evt;
            end
            ST_DISCARD: begin
                win_abort = bypass | stop_evt;
                disc_take = ~bypass & ~stop_evt & res_valid;
            end
            ST_INTEG: begin
                win_abort = bypass | stop_evt;
                acc_take  = ~bypass & ~stop_evt & res_valid;
                cyc_done  = ~bypass & ~stop_evt & res_valid & vals_last;
            end
            default: begin
                win_abort = 1'b1;
            end
        endcase
    end

    assert_bypass_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |=> (state_q == ST_IDLE));

    assert_ext_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) && stop_evt |=> (state_q == ST_IDLE));

    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_INTEG) && start_evt && !stop_evt && !bypass && !res_valid
        |=> (state_q == ST_INTEG));

endmodule

// File: rtl/intwin_datapath.sv
module intwin_datapath #(
    parameter int DW   = 15,
    parameter int CNTW = 5,
    parameter int REPW = 3,
    localparam int ACCW = DW + CNTW
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bypass,
    input  logic                   win_start,
    input  logic                   win_abort,
    input  logic                   disc_take,
    input  logic                   acc_take,
    input  logic                   cyc_done,
    input  logic [CNTW-1:0]        discard_cnt,
    input  logic [CNTW-1:0]        integ_cnt,
    input  logic [REPW-1:0]        repeat_val,
    input  logic signed [DW-1:0]   res_data,
    input  logic                   res_valid,
    output logic                   disc_zero,
    output logic                   disc_last,
    output logic                   vals_last,
    output logic                   cycle_last,
    output logic signed [ACCW-1:0] sum_out,
    output logic                   sum_valid,
    output logic [CNTW-1:0]        vals_counted,
    output logic [REPW-1:0]        cycle_count
);

    logic [CNTW-1:0]        disc_seen_q;
    logic [CNTW-1:0]        vals_q;
    logic [REPW-1:0]        cycles_q;
    logic signed [ACCW-1:0] acc_q;
    logic signed [ACCW-1:0] res_ext;
    logic signed [ACCW-1:0] acc_sum;

    assign res_ext = {{CNTW{res_data[DW-1]}}, res_data};
    assign acc_sum = acc_q + res_ext;

    assign disc_zero  = (discard_cnt == '0);
    assign disc_last  = ({1'b0, disc_seen_q} + {{CNTW{1'b0}}, 1'b1}) == {1'b0, discard_cnt};
    assign vals_last  = (vals_q == integ_cnt);
    assign cycle_last = (cycles_q == repeat_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            disc_seen_q <= '0;
            vals_q      <= '0;
            cycles_q    <= '0;
            acc_q       <= '0;
            sum_out     <= '0;
            sum_valid   <= 1'b0;
        end else begin
            sum_valid <= 1'b0;
            if (win_start) begin
                disc_seen_q <= '0;
                vals_q      <= '0;
                cycles_q    <= '0;
                acc_q       <= '0;
            end else if (win_abort) begin
                disc_seen_q <= '0;
                vals_q      <= '0;
                acc_q       <= '0;
            end else if (disc_take) begin
                disc_seen_q <= disc_seen_q + 1'b1;
            end else if (acc_take) begin
                if (cyc_done) begin
                    sum_out   <= acc_sum;
                    sum_valid <= 1'b1;
                    acc_q     <= '0;
                    vals_q    <= '0;
                    cycles_q  <= cycles_q + 1'b1;
                end else begin
                    acc_q  <= acc_sum;
                    vals_q <= vals_q + 1'b1;
                end
            end
            if (bypass && res_valid) begin
                sum_out   <= res_ext;
                sum_valid <= 1'b1;
            end
        end
    end

    assign vals_counted = vals_q;
    assign cycle_count  = cycles_q;

    assert_clear_after_sum_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sum_valid && !$past(bypass) |-> (vals_q == '0) && (acc_q == '0));

    assert_cycle_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !win_start |=> (cycles_q == $past(cycles_q)) || (cycles_q == $past(cycles_q) + 1'b1));

endmodule

// File: rtl/intwin_ctrl.sv
module intwin_ctrl
    import intwin_pkg::*;
#(
    parameter int DW   = 15,
    parameter int CNTW = 5,
    parameter int REPW = 3,
    localparam int ACCW = DW + CNTW
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             trig_mode,
    input  logic                   win_ext,
    input  logic [CNTW-1:0]        discard_cnt,
    input  logic [CNTW-1:0]        integ_cnt,
    input  logic [REPW-1:0]        repeat_val,
    input  logic                   trig_in,
    input  logic signed [DW-1:0]   res_data,
    input  logic                   res_valid,
    output logic signed [ACCW-1:0] sum_out,
    output logic                   sum_valid,
    output logic [CNTW-1:0]        vals_counted,
    output logic [REPW-1:0]        cycle_count,
    output logic                   integ_en
);

    trig_mode_e mode;
    win_state_e state_q;
    logic bypass, always_on;
    logic start_evt, stop_evt;
    logic win_start, win_abort, disc_take, acc_take, cyc_done;
    logic disc_zero, disc_last, vals_last, cycle_last;

    assign mode      = trig_mode_e'(trig_mode);
    assign bypass    = (mode == TRM_BYPASS);
    assign always_on = (mode == TRM_ALWAYS);

    intwin_trig u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .win_ext   (win_ext),
        .trig_in   (trig_in),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    intwin_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .bypass     (bypass),
        .always_on  (always_on),
        .win_ext    (win_ext),
        .start_evt  (start_evt),
        .stop_evt   (stop_evt),
        .res_valid  (res_valid),
        .disc_zero  (disc_zero),
        .disc_last  (disc_last),
        .vals_last  (vals_last),
        .cycle_last (cycle_last),
        .state_q    (state_q),
        .win_start  (win_start),
        .win_abort  (win_abort),
        .disc_take  (disc_take),
        .acc_take   (acc_take),
        .cyc_done   (cyc_done)
    );

    intwin_datapath #(
        .DW   (DW),
        .CNTW (CNTW),
        .REPW (REPW)
    ) u_dp (
        .clk          (clk),
        .rst_n        (rst_n),
        .bypass       (bypass),
        .win_start    (win_start),
        .win_abort    (win_abort),
        .disc_take    (disc_take),
        .acc_take     (acc_take),
        .cyc_done     (cyc_done),
        .discard_cnt  (discard_cnt),
        .integ_cnt    (integ_cnt),
        .repeat_val   (repeat_val),
        .res_data     (res_data),
        .res_valid    (res_valid),
        .disc_zero    (disc_zero),
        .disc_last    (disc_last),
        .vals_last    (vals_last),
        .cycle_last   (cycle_last),
        .sum_out      (sum_out),
        .sum_valid    (sum_valid),
        .vals_counted (vals_counted),
        .cycle_count  (cycle_count)
    );

    assign integ_en = always_on | (state_q != ST_IDLE);

    assert_always_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_mode == 2'd3) |-> integ_en);

    assert_bypass_en_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_mode == 2'd0) |=> (trig_mode != 2'd0) || !integ_en);

endmodule

// File: tb/intwin_ctrl_tb_top.sv
`timescale 1ns/1ps
module intwin_ctrl_tb_top;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [1:0]         trig_mode = 2'd0;
    logic               win_ext = 1'b0;
    logic [4:0]         discard_cnt = '0;
    logic [4:0]         integ_cnt = '0;
    logic [2:0]         repeat_val = '0;
    logic               trig_in = 1'b0;
    logic signed [14:0] res_data = '0;
    logic               res_valid = 1'b0;
    logic signed [19:0] sum_out;
    logic               sum_valid;
    logic [4:0]         vals_counted;
    logic [2:0]         cycle_count;
    logic               integ_en;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    intwin_ctrl dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .trig_mode    (trig_mode),
        .win_ext      (win_ext),
        .discard_cnt  (discard_cnt),
        .integ_cnt    (integ_cnt),
        .repeat_val   (repeat_val),
        .trig_in      (trig_in),
        .res_data     (res_data),
        .res_valid    (res_valid),
        .sum_out      (sum_out),
        .sum_valid    (sum_valid),
        .vals_counted (vals_counted),
        .cycle_count  (cycle_count),
        .integ_en     (integ_en)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push(input int v);
        res_data  = 15'(v);
        res_valid = 1'b1;
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    task automatic set_trig(input logic b);
        trig_in = b;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic test_reset();
        chk("R1 reset integ_en", int'(integ_en), 0);
        chk("R5 reset sum_valid", int'(sum_valid), 0);
        chk("R6 reset vals_counted", int'(vals_counted), 0);
        chk("R7 reset cycle_count", int'(cycle_count), 0);
    endtask

    task automatic test_bypass();
        trig_mode = 2'd0;
        push(100);
        chk("R1 bypass valid", int'(sum_valid), 1);
        chk("R1 bypass value", int'(sum_out), 100);
        push(-5);
        chk("R1 bypass negative", int'(sum_out), -5);
        set_trig(1'b1);
        chk("R1 edge ignored", int'(integ_en), 0);
        chk("R1 no stray pulse", int'(sum_valid), 0);
        set_trig(1'b0);
        chk("R1 still bypassed", int'(integ_en), 0);
    endtask

    task automatic test_rise_internal();
        trig_mode = 2'd2; win_ext = 1'b0;
        discard_cnt = 5'd2; integ_cnt = 5'd2; repeat_val = 3'd1;
        @(negedge clk);
        push(7);
        chk("R3 no window before edge", int'(sum_valid), 0);
        chk("R3 disabled before edge", int'(integ_en), 0);
        set_trig(1'b1);
        chk("R3 rising opens", int'(integ_en), 1);
        push(1000);
        chk("R4 discard one", int'(vals_counted), 0);
        push(2000);
        chk("R4 discard two", int'(vals_counted), 0);
        push(10);
        chk("R6 count one", int'(vals_counted), 1);
        push(20);
        chk("R6 count two", int'(vals_counted), 2);
        push(30);
        chk("R5 pulse", int'(sum_valid), 1);
        chk("R5 sum", int'(sum_out), 60);
        chk("R5 vals cleared", int'(vals_counted), 0);
        chk("R7 one group", int'(cycle_count), 1);
        chk("R7 still open", int'(integ_en), 1);
        @(negedge clk);
        chk("R5 single cycle pulse", int'(sum_valid), 0);
        push(1); push(2); push(3);
        chk("R5 second sum", int'(sum_out), 6);
        chk("R7 two groups", int'(cycle_count), 2);
        chk("R7 window closed", int'(integ_en), 0);
        push(50);
        chk("R7 no sum after close", int'(sum_valid), 0);
        set_trig(1'b0);
    endtask

    task automatic test_fall_external();
        trig_mode = 2'd1; win_ext = 1'b1;
        discard_cnt = 5'd0; integ_cnt = 5'd1; repeat_val = 3'd0;
        set_trig(1'b1);
        chk("R3 rising ignored in falling mode", int'(integ_en), 0);
        set_trig(1'b0);
        chk("R3 falling opens", int'(integ_en), 1);
        push(5); push(6);
        chk("R4 zero discard sum", int'(sum_out), 11);
        push(7); push(8);
        chk("R8 second sum", int'(sum_out), 15);
        chk("R8 repeat_val ignored", int'(integ_en), 1);
        chk("R8 groups counted", int'(cycle_count), 2);
        push(9);
        chk("R6 partial", int'(vals_counted), 1);
        set_trig(1'b1);
        chk("R8 opposite edge closes", int'(integ_en), 0);
        chk("R8 partial dropped vals", int'(vals_counted), 0);
        chk("R8 no pulse on close", int'(sum_valid), 0);
        push(4);
        chk("R8 closed stays quiet", int'(sum_valid), 0);
        set_trig(1'b0);
        chk("R3 new falling edge reopens", int'(integ_en), 1);
        trig_mode = 2'd0;
        @(negedge clk);
        chk("R1 bypass ends window", int'(integ_en), 0);
    endtask

    task automatic test_ignore_edges();
        trig_mode = 2'd2; win_ext = 1'b0;
        discard_cnt = 5'd1; integ_cnt = 5'd0; repeat_val = 3'd3;
        @(negedge clk);
        set_trig(1'b1);
        push(99);
        push(3);
        chk("R4 one discarded", int'(sum_out), 3);
        chk("R9 group one", int'(cycle_count), 1);
        set_trig(1'b0);
        chk("R8 internal ignores fall", int'(integ_en), 1);
        set_trig(1'b1);
        chk("R9 still open", int'(integ_en), 1);
        chk("R9 cycle not cleared", int'(cycle_count), 1);
        push(4);
        chk("R9 no new discard", int'(sum_valid), 1);
        chk("R9 sum after edge", int'(sum_out), 4);
        push(1); push(1);
        chk("R7 four groups", int'(cycle_count), 4);
        chk("R7 closed after four", int'(integ_en), 0);
        set_trig(1'b0);
    endtask

    task automatic test_always_full_scale();
        trig_mode = 2'd3; win_ext = 1'b0;
        discard_cnt = 5'd0; integ_cnt = 5'd31; repeat_val = 3'd0;
        @(negedge clk);
        chk("R2 always enabled", int'(integ_en), 1);
        for (int i = 0; i < 31; i++) push(-16384);
        chk("R6 thirty one counted", int'(vals_counted), 31);
        push(-16384);
        chk("R10 negative full scale", int'(sum_out), -524288);
        chk("R2 no stop", int'(integ_en), 1);
        for (int i = 0; i < 32; i++) push(16383);
        chk("R10 positive full scale", int'(sum_out), 524256);
        chk("R2 keeps running", int'(cycle_count), 2);
        trig_mode = 2'd0;
        @(negedge clk);
        chk("R1 back to bypass", int'(integ_en), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_bypass();
        test_rise_internal();
        test_fall_external();
        test_ignore_edges();
        test_always_full_scale();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

endmodule